// File: doc/BRIEF.md
# Clock Policy Mask Controller

This block keeps one clock-enable mask for each power policy and drives a bank of clock enables from the mask that belongs to the policy currently in force. Software reaches it through a plain word-addressed register bus: address, write data, write strobe, and combinational read data. An active-policy input selects the policy. The controller registers that input and applies the matching mask to its enable outputs.

Software can rewrite the masks only while the policy engine is halted. It halts the engine by setting a bit in the control register, rewrites the masks, and then issues a start command. The start command carries one of two mode flags. On the cycle after the start command, the new masks reach the outputs and the engine resumes. Writes to the bus are refused until a password word has been written to the register at address zero. Writing any other word to that register closes write access again.

Top module: `clk_policy_mask_ctrl`

## Requirements
- R1: While the engine runs, the active-policy input is registered on one edge. On the next edge, the enables take the mask of that registered policy, so a policy change reaches the outputs two edges later. Bit k of the enables is clock k.
- R2: The mask for policy i sits at word address 4+i in bits [15:0], and reads back there. Bit k of every mask controls clock k.
- R3: A mask write while the engine runs leaves the masks unchanged and sets a sticky error flag, read at control bit 4. A control write with bit 4 set clears that flag.
- R4: Control register (address 1) bit 0 halts the engine. While the engine is halted and no start is pending, the enables keep their last applied value whatever the policy input does.
- R5: A control write with bit 1 (start) and at least one of bit 2 or bit 3 (mode flags) set makes start read as 1. On the next edge the enables load the mask of the registered policy, the engine runs, and start reads 0 again. The mode flags are latched and read back at bits [3:2].
- R6: A control write with bit 1 set and both mode flags clear is ignored entirely. The halt, error, start and mode state do not change.
- R7: Writing the password word 32'h5EC7_0A0D to address 0 opens write access, and read bit 0 of address 0 returns 1.
- R8: Writing any other value to address 0 closes write access, and read bit 0 returns 0.
- R9: While write access is closed, writes to every address other than 0 have no effect and do not set the error flag.
- R10: After reset, write access is closed, the engine runs, start, mode and error read 0, every mask holds 16'hFFFF, the enables are all ones, and the registered policy is 0.
- R11: Addresses 2, 3 and 8 to 15 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| policy_sel_i | input | 2 | Active power policy |
| clk_en_o | output | 16 | Clock enables |

## Verification
The assertions check several rules on every cycle. Halted enables stay still, and a running engine loads the mask of the registered policy. Start clears itself after one cycle and leaves the engine running. Masks do not move on a refused or locked write, and the error flag stays set until cleared. Write access follows the last word written to address zero. Other behaviours show only in the bench scenarios, which compare every output against a reference model: a start request with no mode flag being dropped, the exact two-edge policy latency, the mode flags read back, and unmapped addresses reading zero.

// File: rtl/clkpol_pkg.sv
package clkpol_pkg;

    localparam int unsigned ADDR_ACCESS = 0;
    localparam int unsigned ADDR_CTRL   = 1;
    localparam int unsigned MASK_BASE   = 4;

    localparam int unsigned CB_HALT    = 0;
    localparam int unsigned CB_START   = 1;
    localparam int unsigned CB_MODE_LO = 2;
    localparam int unsigned CB_MODE_HI = 3;
    localparam int unsigned CB_ERR     = 4;
    localparam int unsigned CTRL_W     = 5;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_ACCESS = 2'd1,
        RK_CTRL   = 2'd2,
        RK_MASK   = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/clkpol_bus_front.sv
module clkpol_bus_front
    import clkpol_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N_POL    = 4,
    parameter logic [DATA_W-1:0] PASSWORD = 32'h5EC7_0A0D,
    localparam int unsigned PIDX_W  = (N_POL > 1) ? $clog2(N_POL) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output reg_kind_e         kind_o,
    output logic [PIDX_W-1:0] idx_o,
    output logic              unlocked_o,
    output logic              wr_ctrl_o,
    output logic              wr_mask_o
);

    typedef struct packed {
        logic unlocked;
    } front_t;

    front_t st_d, st_q;
    reg_kind_e kind;
    logic [ADDR_W-1:0] rel_addr;

    always_comb begin
        rel_addr = addr_i - ADDR_W'(MASK_BASE);
        if (addr_i == ADDR_W'(ADDR_ACCESS)) begin
            kind = RK_ACCESS;
        end else if (addr_i == ADDR_W'(ADDR_CTRL)) begin
            kind = RK_CTRL;
        end else if ((addr_i >= ADDR_W'(MASK_BASE)) && (rel_addr < ADDR_W'(N_POL))) begin
            kind = RK_MASK;
        end else begin
            kind = RK_NONE;
        end

        st_d = st_q;
        if (we_i && (kind == RK_ACCESS)) begin
            st_d.unlocked = (wdata_i == PASSWORD);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o     = kind;
    assign idx_o      = rel_addr[PIDX_W-1:0];
    assign unlocked_o = st_q.unlocked;
    assign wr_ctrl_o  = we_i && st_q.unlocked && (kind == RK_CTRL);
    assign wr_mask_o  = we_i && st_q.unlocked && (kind == RK_MASK);

    a_r7_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(ADDR_ACCESS) && wdata_i == PASSWORD) |=> unlocked_o);

    a_r8_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(ADDR_ACCESS) && wdata_i != PASSWORD) |=> !unlocked_o);

    a_r9_no_strobe_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked_o && !(we_i && addr_i == ADDR_W'(ADDR_ACCESS))) |=> !unlocked_o);

endmodule

// File: rtl/clkpol_mask_bank.sv
module clkpol_mask_bank #(
    parameter int unsigned N_POL   = 4,
    parameter int unsigned N_CLK   = 16,
    localparam int unsigned PIDX_W = (N_POL > 1) ? $clog2(N_POL) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_mask_i,
    input  logic [PIDX_W-1:0]           idx_i,
    input  logic [N_CLK-1:0]            wdata_i,
    input  logic                        halted_i,
    output logic [N_POL-1:0][N_CLK-1:0] masks_o,
    output logic                        reject_o
);

    logic [N_POL-1:0][N_CLK-1:0] mask_d, mask_q;
    logic [N_POL-1:0]            hit;

    for (genvar g = 0; g < N_POL; g++) begin : g_hit
        assign hit[g] = wr_mask_i && halted_i && (idx_i == PIDX_W'(g));
    end

    always_comb begin
        mask_d = mask_q;
        for (int i = 0; i < N_POL; i++) begin
            if (hit[i]) begin
                mask_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign masks_o  = mask_q;
    assign reject_o = wr_mask_i && !halted_i;

    a_r3_refused_write_keeps_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_mask_i && !halted_i) |=> $stable(masks_o));

    a_r2_idle_keeps_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_mask_i |=> $stable(masks_o));

endmodule

// File: rtl/clkpol_engine.sv
module clkpol_engine
    import clkpol_pkg::*;
#(
    parameter int unsigned N_POL   = 4,
    parameter int unsigned N_CLK   = 16,
    localparam int unsigned PIDX_W = (N_POL > 1) ? $clog2(N_POL) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_ctrl_i,
    input  logic [CTRL_W-1:0]           ctrl_wdata_i,
    input  logic                        reject_i,
    input  logic [N_POL-1:0][N_CLK-1:0] masks_i,
    input  logic [PIDX_W-1:0]           policy_i,
    output logic [N_CLK-1:0]            en_o,
    output logic                        halt_o,
    output logic                        start_o,
    output logic [1:0]                  mode_o,
    output logic                        err_o
);

    typedef struct packed {
        logic [PIDX_W-1:0] pol;
        logic [N_CLK-1:0]  en;
        logic              halt;
        logic              start;
        logic [1:0]        mode;
        logic              err;
    } eng_t;

    eng_t st_d, st_q;
    logic              start_req;
    logic              mode_any;
    logic [N_CLK-1:0]  sel_mask;

    assign sel_mask  = masks_i[st_q.pol];
    assign start_req = ctrl_wdata_i[CB_START];
    assign mode_any  = |ctrl_wdata_i[CB_MODE_HI:CB_MODE_LO];

    always_comb begin
        st_d     = st_q;
        st_d.pol = policy_i;

        if (st_q.start) begin
            st_d.en    = sel_mask;
            st_d.start = 1'b0;
            st_d.halt  = 1'b0;
        end else if (!st_q.halt) begin
            st_d.en = sel_mask;
        end

        if (reject_i) begin
            st_d.err = 1'b1;
        end

        if (wr_ctrl_i && !(start_req && !mode_any)) begin
            st_d.halt = ctrl_wdata_i[CB_HALT];
            if (ctrl_wdata_i[CB_ERR]) begin
                st_d.err = 1'b0;
            end
            if (start_req) begin
                st_d.start = 1'b1;
                st_d.mode  = ctrl_wdata_i[CB_MODE_HI:CB_MODE_LO];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.en    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign halt_o  = st_q.halt;
    assign start_o = st_q.start;
    assign mode_o  = st_q.mode;
    assign err_o   = st_q.err;

    a_r1_running_follows_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.halt && !st_q.start) |=> (en_o == $past(sel_mask)));

    a_r4_halted_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.halt && !st_q.start) |=> $stable(en_o));

    a_r5_start_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.start && !wr_ctrl_i) |=> (!start_o && !halt_o));

    a_r3_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.err && !wr_ctrl_i) |=> err_o);

endmodule

// File: rtl/clk_policy_mask_ctrl.sv
module clk_policy_mask_ctrl
    import clkpol_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N_POL    = 4,
    parameter int unsigned N_CLK    = 16,
    parameter logic [DATA_W-1:0] PASSWORD = 32'h5EC7_0A0D,
    localparam int unsigned PIDX_W  = (N_POL > 1) ? $clog2(N_POL) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [PIDX_W-1:0] policy_sel_i,
    output logic [N_CLK-1:0]  clk_en_o
);

    reg_kind_e                   kind;
    logic [PIDX_W-1:0]           idx;
    logic                        unlocked;
    logic                        wr_ctrl;
    logic                        wr_mask;
    logic                        reject;
    logic                        halt;
    logic                        start;
    logic [1:0]                  mode;
    logic                        err;
    logic [N_POL-1:0][N_CLK-1:0] masks;
    logic [CTRL_W-1:0]           ctrl_rd;

    clkpol_bus_front #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N_POL   (N_POL),
        .PASSWORD(PASSWORD)
    ) front_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .we_i      (bus_we_i),
        .kind_o    (kind),
        .idx_o     (idx),
        .unlocked_o(unlocked),
        .wr_ctrl_o (wr_ctrl),
        .wr_mask_o (wr_mask)
    );

    clkpol_mask_bank #(
        .N_POL(N_POL),
        .N_CLK(N_CLK)
    ) bank_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_mask_i(wr_mask),
        .idx_i    (idx),
        .wdata_i  (bus_wdata_i[N_CLK-1:0]),
        .halted_i (halt),
        .masks_o  (masks),
        .reject_o (reject)
    );

    clkpol_engine #(
        .N_POL(N_POL),
        .N_CLK(N_CLK)
    ) engine_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_ctrl_i   (wr_ctrl),
        .ctrl_wdata_i(bus_wdata_i[CTRL_W-1:0]),
        .reject_i    (reject),
        .masks_i     (masks),
        .policy_i    (policy_sel_i),
        .en_o        (clk_en_o),
        .halt_o      (halt),
        .start_o     (start),
        .mode_o      (mode),
        .err_o       (err)
    );

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[CB_HALT]   = halt;
        ctrl_rd[CB_START]  = start;
        ctrl_rd[CB_MODE_HI:CB_MODE_LO] = mode;
        ctrl_rd[CB_ERR]    = err;
        unique case (kind)
            RK_ACCESS: bus_rdata_o = DATA_W'(unlocked);
            RK_CTRL:   bus_rdata_o = DATA_W'(ctrl_rd);
            RK_MASK:   bus_rdata_o = DATA_W'(masks[idx]);
            default:   bus_rdata_o = '0;
        endcase
    end

    a_r9_closed_write_no_mask_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && !unlocked && bus_addr_i != '0) |=> $stable(masks));

    a_r9_closed_write_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && !unlocked && !err) |=> !err);

endmodule

// File: tb/clk_policy_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_policy_mask_ctrl_tb_top;

    localparam logic [31:0] PW = 32'h5EC7_0A0D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [1:0]  pol = '0;
    logic [31:0] rdata;
    logic [15:0] en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        m_unl, m_halt, m_go, m_err;
    logic [1:0]  m_mode, m_pol;
    logic [15:0] m_en;
    logic [15:0] m_mask [4];

    always #2 clk = ~clk;

    clk_policy_mask_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .policy_sel_i(pol),
        .clk_en_o    (en)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'd0)      return {31'b0, m_unl};
        else if (a == 4'd1) return {27'b0, m_err, m_mode, m_go, m_halt};
        else if (a >= 4'd4 && a <= 4'd7) return {16'b0, m_mask[a - 4'd4]};
        else                return 32'b0;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [1:0] p, input string tag);
        logic        n_unl, n_halt, n_go, n_err;
        logic [1:0]  n_mode, n_pol;
        logic [15:0] n_en;
        logic [15:0] n_mask [4];
        @(negedge clk);
        we = w; addr = a; wdata = d; pol = p;
        n_unl = m_unl; n_halt = m_halt; n_go = m_go; n_err = m_err;
        n_mode = m_mode; n_en = m_en; n_mask = m_mask;
        n_pol = p;
        if (m_go) begin
            n_en = m_mask[m_pol]; n_go = 1'b0; n_halt = 1'b0;
        end else if (!m_halt) begin
            n_en = m_mask[m_pol];
        end
        if (w) begin
            if (a == 4'd0) begin
                n_unl = (d == PW);
            end else if (m_unl) begin
                if (a == 4'd1) begin
                    if (!(d[1] && d[3:2] == 2'b00)) begin
                        n_halt = d[0];
                        if (d[4]) n_err = 1'b0;
                        if (d[1]) begin n_go = 1'b1; n_mode = d[3:2]; end
                    end
                end else if (a >= 4'd4 && a <= 4'd7) begin
                    if (m_halt) n_mask[a - 4'd4] = d[15:0];
                    else        n_err = 1'b1;
                end
            end
        end
        @(posedge clk);
        #1;
        m_unl = n_unl; m_halt = n_halt; m_go = n_go; m_err = n_err;
        m_mode = n_mode; m_pol = n_pol; m_en = n_en; m_mask = n_mask;
        check(tag, "clk_en", {16'b0, en}, {16'b0, m_en});
        check(tag, "rdata", rdata, model_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_unl = 0; m_halt = 0; m_go = 0; m_err = 0; m_mode = 0; m_pol = 0;
        m_en = 16'hFFFF;
        for (int i = 0; i < 4; i++) m_mask[i] = 16'hFFFF;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        check("R10", "clk_en after reset", {16'b0, en}, 32'h0000_FFFF);
        step(0, 4'd0, 0, 0, "R10");
        step(0, 4'd1, 0, 0, "R10");
        step(0, 4'd6, 0, 0, "R10");

        // R9: writes while closed have no effect
        step(1, 4'd1, 32'h1, 0, "R9");
        step(1, 4'd4, 32'h1234, 0, "R9");
        step(0, 4'd1, 0, 0, "R9");
        step(0, 4'd4, 0, 0, "R9");

        // R7: unlock
        step(1, 4'd0, PW, 0, "R7");
        step(0, 4'd0, 0, 0, "R7");

        // R4: halt, then masks rewritten, outputs hold while policy moves
        step(1, 4'd1, 32'h1, 0, "R4");
        step(1, 4'd4, 32'h00F0, 0, "R2");
        step(1, 4'd5, 32'hA5A5, 1, "R2");
        step(1, 4'd6, 32'h0001, 2, "R2");
        step(1, 4'd7, 32'h8000, 3, "R2");
        step(0, 4'd5, 0, 2, "R4");
        step(0, 4'd7, 0, 1, "R4");

        // R6: start with no mode flag is dropped
        step(1, 4'd1, 32'h0000_0012, 1, "R6");
        step(0, 4'd1, 0, 1, "R6");
        step(0, 4'd1, 0, 1, "R6");

        // R5: start with mode flag A
        step(1, 4'd1, 32'h0000_0007, 1, "R5");
        step(0, 4'd1, 0, 1, "R5");
        step(0, 4'd1, 0, 1, "R5");

        // R1: running, policy changes with two-edge latency
        step(0, 4'd0, 0, 2, "R1");
        step(0, 4'd0, 0, 3, "R1");
        step(0, 4'd0, 0, 0, "R1");
        step(0, 4'd0, 0, 0, "R1");

        // R3: mask write while running is refused and flagged
        step(1, 4'd4, 32'hFFFF, 0, "R3");
        step(0, 4'd1, 0, 0, "R3");
        step(0, 4'd4, 0, 0, "R3");
        step(1, 4'd1, 32'h0000_0010, 0, "R3");
        step(0, 4'd1, 0, 0, "R3");

        // R5: start with mode flag B after a halted update
        step(1, 4'd1, 32'h1, 0, "R5");
        step(1, 4'd4, 32'h0F0F, 0, "R5");
        step(1, 4'd1, 32'h0000_000A, 0, "R5");
        step(0, 4'd1, 0, 0, "R5");

        // R11: unmapped addresses
        step(1, 4'd2, 32'hFFFF_FFFF, 0, "R11");
        step(1, 4'd9, 32'hFFFF_FFFF, 0, "R11");
        step(0, 4'd15, 0, 0, "R11");
        step(0, 4'd1, 0, 0, "R11");

        // R8: wrong password closes access; later writes do nothing
        step(1, 4'd0, PW ^ 32'h1, 0, "R8");
        step(0, 4'd0, 0, 0, "R8");
        step(1, 4'd1, 32'h1, 0, "R9");
        step(0, 4'd1, 0, 0, "R9");

        // R1: constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  ra;
            logic [31:0] rd;
            logic        rw;
            int          sel;
            sel = $urandom_range(0, 9);
            if (sel < 2)      ra = 4'd0;
            else if (sel < 5) ra = 4'd1;
            else if (sel < 9) ra = 4'(4 + $urandom_range(0, 3));
            else              ra = 4'($urandom_range(0, 15));
            rw = ($urandom_range(0, 9) < 6);
            if (ra == 4'd0)      rd = ($urandom_range(0, 9) < 7) ? PW : $urandom();
            else if (ra == 4'd1) rd = {27'b0, 5'($urandom_range(0, 31))};
            else                 rd = $urandom();
            step(rw, ra, rd, 2'($urandom_range(0, 3)), "R1");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule